// File: doc/BRIEF.md
# Synchronous Ethernet Timing Reference Selector

This block decides which frequency source a synchronous-Ethernet switch locks its system clock to. The candidates are one external clock input, the local free-running oscillator, and the receive clock recovered on each of `N_PORTS` line ports. For every candidate except the oscillator, the block receives a 4-bit quality level learned from the upstream neighbour's synchronization status messages, a failure flag, and a configured priority. The oscillator supplies only its own quality level and is always usable.

Each cycle, the selector ranks the usable candidates by quality, then by priority, then by index. It moves to a newly better candidate only after that candidate has stayed best for a programmable number of tick pulses. When the current reference becomes unusable, it switches at once. When no external or port source is usable, it rests on the oscillator. It outputs the selection as an index and as a one-hot vector, together with the quality level the switch should claim for itself. It also gives a per-port advertised quality that carries the do-not-use code toward the port the clock is taken from, so that a timing loop cannot form. The choice depends on no data-forwarding state, so a port that spanning tree has blocked is as eligible as any other.

Top module: `sync_ref_selector`

## Requirements
- R1: While reset is asserted, the selection is the oscillator (index 1, one-hot bit 1). The system quality and every port's advertised quality are 15.
- R2: The external source or a port is eligible only when its failure flag is low and its quality is not 15, the do-not-use code. An ineligible source is never selected. The oscillator is always eligible.
- R3: Among eligible external and port sources, the one with the numerically lowest quality code (lower is better) is the best.
- R4: When qualities tie, the source with the lower priority value is the best.
- R5: When quality and priority both tie, the lowest index is the best. Index 0 is the external input, index 1 is the oscillator, and index 2+p is port p.
- R6: While the current selection is eligible, a different best source is adopted only after it has stayed best for `hold_ticks` tick cycles following its first cycle as best. A change of best source restarts that count. With `hold_ticks` at 0, the switch happens at the first clock edge.
- R7: When the current selection becomes ineligible, the best source is selected at the next clock edge, with no hold-off. This also holds when a different source improves in the same cycle.
- R8: The oscillator is selected only when no external or port source is eligible, apart from the hold-off delay of R6. While it is selected, the system quality equals `osc_ql`.
- R9: The system quality equals the quality input of the selected source. Every port advertises the system quality, except the selected port, which advertises 15.
- R10: `sel_idx` and `sel_onehot` name the same source. All outputs are registered and change at the clock edge where the decision is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Hold-off time base, one pulse per counted interval |
| hold_ticks | input | HOLD_W | Ticks a new best source must persist before adoption |
| ext_ql | input | 4 | Quality level of the external input |
| ext_fail | input | 1 | External input failed |
| ext_prio | input | PRIO_W | Priority of the external input, lower wins |
| osc_ql | input | 4 | Quality level of the local oscillator |
| port_ql | input | N_PORTS*4 | Received quality level per port, port p at bits [4p+3:4p] |
| port_fail | input | N_PORTS | Recovered clock of port p failed |
| port_prio | input | N_PORTS*PRIO_W | Priority per port, lower wins |
| sel_idx | output | IDX_W | Selected source index |
| sel_onehot | output | N_PORTS+2 | Selected source, one bit per index |
| sys_ql | output | 4 | Quality level of the selected reference |
| port_adv_ql | output | N_PORTS*4 | Quality level to advertise on each port |

## Verification
The hold-off path and the failover path can act in the same cycle. This happens when the current reference fails at the same moment that another source becomes the best. The bench provokes this by setting a long hold-off and then, in one drive, failing the selected port while raising a different port to the best quality. The result passes only if the new port is selected one edge later and the advertised qualities follow in that same cycle. A second collision, where a fresh candidate replaces a pending one partway through the count, is judged by confirming that no switch occurs until the full tick count has run again for the newer candidate.

// File: rtl/sref_pkg.sv
package sref_pkg;
    localparam int unsigned QL_W = 4;
    typedef logic [QL_W-1:0] ql_t;
    localparam ql_t QL_DNU = '1;
    localparam int SRC_EXT   = 0;
    localparam int SRC_OSC   = 1;
    localparam int SRC_PORT0 = 2;
endpackage

// File: rtl/sref_qualify.sv
module sref_qualify
    import sref_pkg::*;
#(
    parameter int unsigned N_SRC = 6
) (
    input  logic [N_SRC*QL_W-1:0] src_ql,
    input  logic [N_SRC-1:0]      src_fail,
    output logic [N_SRC-1:0]      src_elig
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g == SRC_OSC) begin : g_osc
            // free-running oscillator: usable whatever it advertises
            assign src_elig[g] = ~src_fail[g];
        end else begin : g_line
            // a do-not-use code from upstream marks a loop path
            assign src_elig[g] = ~src_fail[g] && (src_ql[g*QL_W +: QL_W] != QL_DNU);
        end
    end
endmodule

// File: rtl/sref_rank.sv
module sref_rank
    import sref_pkg::*;
#(
    parameter int unsigned N_SRC  = 6,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [N_SRC*QL_W-1:0]   src_ql,
    input  logic [N_SRC-1:0]        src_elig,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    output logic [IDX_W-1:0]        best_idx
);
    always_comb begin
        ql_t               top_ql;
        logic [PRIO_W-1:0] top_pr;
        logic              found;
        best_idx = IDX_W'(SRC_OSC);
        top_ql   = QL_DNU;
        top_pr   = '1;
        found    = 1'b0;
        // ascending scan with strict compares keeps the lowest index on ties
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (i != SRC_OSC && src_elig[i]) begin
                if (!found
                    || (src_ql[i*QL_W +: QL_W] < top_ql)
                    || ((src_ql[i*QL_W +: QL_W] == top_ql)
                        && (src_prio[i*PRIO_W +: PRIO_W] < top_pr))) begin
                    best_idx = IDX_W'(i);
                    top_ql   = src_ql[i*QL_W +: QL_W];
                    top_pr   = src_prio[i*PRIO_W +: PRIO_W];
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sref_switch.sv
module sref_switch
    import sref_pkg::*;
#(
    parameter int unsigned N_SRC  = 6,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [HOLD_W-1:0] hold_ticks,
    input  logic [IDX_W-1:0]  best_idx,
    input  logic [N_SRC-1:0]  src_elig,
    output logic [IDX_W-1:0]  sel_q_o,
    output logic [IDX_W-1:0]  sel_d_o
);
    localparam int unsigned SPAN = 1 << IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0]  sel;
        logic [IDX_W-1:0]  pend;
        logic [HOLD_W-1:0] cnt;
    } sw_t;

    sw_t               st_d, st_q;
    logic [SPAN-1:0]   elig_ext;
    logic              cur_ok;
    logic [HOLD_W-1:0] cnt_n;

    assign elig_ext = SPAN'(src_elig);
    assign cur_ok   = elig_ext[st_q.sel];

    always_comb begin
        st_d  = st_q;
        cnt_n = '0;
        if (best_idx == st_q.sel) begin
            st_d.pend = st_q.sel;
            st_d.cnt  = '0;
        end else if (!cur_ok) begin
            // lost reference: take the best at once
            st_d.sel  = best_idx;
            st_d.pend = best_idx;
            st_d.cnt  = '0;
        end else begin
            if (best_idx == st_q.pend) begin
                cnt_n = (tick && st_q.cnt != '1) ? st_q.cnt + HOLD_W'(1) : st_q.cnt;
            end
            if (cnt_n >= hold_ticks) begin
                st_d.sel  = best_idx;
                st_d.pend = best_idx;
                st_d.cnt  = '0;
            end else begin
                st_d.pend = best_idx;
                st_d.cnt  = cnt_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel  <= IDX_W'(SRC_OSC);
            st_q.pend <= IDX_W'(SRC_OSC);
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q_o = st_q.sel;
    assign sel_d_o = st_d.sel;

    AST_FAILOVER_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_ok |=> (st_q.sel != $past(st_q.sel))); // R7

    AST_FRESH_BEST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ok && best_idx != st_q.sel && best_idx != st_q.pend && hold_ticks != '0)
        |=> $stable(st_q.sel)); // R6

    AST_NEW_SEL_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.sel != st_q.sel) |-> elig_ext[st_d.sel]); // R2
endmodule

// File: rtl/sref_advert.sv
module sref_advert
    import sref_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned N_SRC   = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        sel_d,
    input  logic [IDX_W-1:0]        sel_q,
    input  logic [N_SRC*QL_W-1:0]   src_ql,
    output logic [QL_W-1:0]         sys_ql,
    output logic [N_PORTS*QL_W-1:0] port_adv_ql
);
    typedef struct packed {
        ql_t                     sys;
        logic [N_PORTS*QL_W-1:0] adv;
    } adv_t;

    adv_t adv_d, adv_q;

    always_comb begin
        adv_d.sys = QL_DNU;
        for (int i = 0; i < int'(N_SRC); i++) begin
            if (sel_d == IDX_W'(i)) adv_d.sys = src_ql[i*QL_W +: QL_W];
        end
        for (int p = 0; p < int'(N_PORTS); p++) begin
            // toward the port feeding the reference, forbid use
            adv_d.adv[p*QL_W +: QL_W] =
                (sel_d == IDX_W'(SRC_PORT0 + p)) ? QL_DNU : adv_d.sys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_q.sys <= QL_DNU;
            adv_q.adv <= '1;
        end else begin
            adv_q <= adv_d;
        end
    end

    assign sys_ql      = adv_q.sys;
    assign port_adv_ql = adv_q.adv;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_loopchk
        AST_NO_LOOP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q == IDX_W'(SRC_PORT0 + p)) |-> (adv_q.adv[p*QL_W +: QL_W] == QL_DNU)); // R9
    end
endmodule

// File: rtl/sync_ref_selector.sv
module sync_ref_selector
    import sref_pkg::*;
#(
    parameter int unsigned N_PORTS = 4,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned HOLD_W  = 8,
    localparam int unsigned N_SRC  = N_PORTS + 2,
    localparam int unsigned IDX_W  = $clog2(N_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [HOLD_W-1:0]         hold_ticks,
    input  logic [QL_W-1:0]           ext_ql,
    input  logic                      ext_fail,
    input  logic [PRIO_W-1:0]         ext_prio,
    input  logic [QL_W-1:0]           osc_ql,
    input  logic [N_PORTS*QL_W-1:0]   port_ql,
    input  logic [N_PORTS-1:0]        port_fail,
    input  logic [N_PORTS*PRIO_W-1:0] port_prio,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [N_SRC-1:0]          sel_onehot,
    output logic [QL_W-1:0]           sys_ql,
    output logic [N_PORTS*QL_W-1:0]   port_adv_ql
);
    logic [N_SRC*QL_W-1:0]   src_ql;
    logic [N_SRC-1:0]        src_fail;
    logic [N_SRC*PRIO_W-1:0] src_prio;
    logic [N_SRC-1:0]        src_elig;
    logic [IDX_W-1:0]        best_idx;
    logic [IDX_W-1:0]        sel_q;
    logic [IDX_W-1:0]        sel_d;

    // index order: external, oscillator, then ports
    assign src_ql   = {port_ql, osc_ql, ext_ql};
    assign src_fail = {port_fail, 1'b0, ext_fail};
    assign src_prio = {port_prio, PRIO_W'(0), ext_prio};

    sref_qualify #(.N_SRC(N_SRC)) u_qualify (
        .src_ql   (src_ql),
        .src_fail (src_fail),
        .src_elig (src_elig)
    );

    sref_rank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_rank (
        .src_ql   (src_ql),
        .src_elig (src_elig),
        .src_prio (src_prio),
        .best_idx (best_idx)
    );

    sref_switch #(.N_SRC(N_SRC), .IDX_W(IDX_W), .HOLD_W(HOLD_W)) u_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold_ticks (hold_ticks),
        .best_idx   (best_idx),
        .src_elig   (src_elig),
        .sel_q_o    (sel_q),
        .sel_d_o    (sel_d)
    );

    sref_advert #(.N_PORTS(N_PORTS), .N_SRC(N_SRC), .IDX_W(IDX_W)) u_advert (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_d       (sel_d),
        .sel_q       (sel_q),
        .src_ql      (src_ql),
        .sys_ql      (sys_ql),
        .port_adv_ql (port_adv_ql)
    );

    assign sel_idx = sel_q;
    for (genvar g = 0; g < N_SRC; g++) begin : g_onehot
        assign sel_onehot[g] = (sel_q == IDX_W'(g));
    end
endmodule

// File: tb/sync_ref_selector_bench.sv
`timescale 1ns/1ps
module sync_ref_selector_bench;
    localparam int NP = 4;
    localparam int PW = 3;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [HW-1:0] hold_ticks = '0;
    logic [3:0]    ext_ql = 4'hF;
    logic          ext_fail = 1'b1;
    logic [PW-1:0] ext_prio = '0;
    logic [3:0]    osc_ql = 4'd11;
    logic [NP*4-1:0]  port_ql = '1;
    logic [NP-1:0]    port_fail = '1;
    logic [NP*PW-1:0] port_prio = '0;
    logic [2:0]    sel_idx;
    logic [NP+1:0] sel_onehot;
    logic [3:0]    sys_ql;
    logic [NP*4-1:0] port_adv_ql;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sync_ref_selector #(.N_PORTS(NP), .PRIO_W(PW), .HOLD_W(HW)) u_sync_ref_selector (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_ticks(hold_ticks),
        .ext_ql(ext_ql), .ext_fail(ext_fail), .ext_prio(ext_prio), .osc_ql(osc_ql),
        .port_ql(port_ql), .port_fail(port_fail), .port_prio(port_prio),
        .sel_idx(sel_idx), .sel_onehot(sel_onehot), .sys_ql(sys_ql),
        .port_adv_ql(port_adv_ql)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // R9, R10 checked on every call beside the named requirement
    task automatic check_sel(input int idx, input int ql, input string tag);
        chk(sel_idx == idx, tag, "sel_idx", sel_idx, idx);
        chk(sel_onehot == (1 << idx), {tag, "/R10"}, "sel_onehot", sel_onehot, 1 << idx);
        chk(sys_ql == ql, {tag, "/R9"}, "sys_ql", sys_ql, ql);
        for (int p = 0; p < NP; p++) begin
            int e = (idx == p + 2) ? 15 : ql;
            chk(port_adv_ql[p*4 +: 4] == e, {tag, "/R9"}, "port_adv_ql", port_adv_ql[p*4 +: 4], e);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_ext(input int ql, input bit fl, input int pr);
        ext_ql = 4'(ql); ext_fail = fl; ext_prio = PW'(pr);
    endtask

    task automatic set_port(input int p, input int ql, input bit fl, input int pr);
        port_ql[p*4 +: 4] = 4'(ql);
        port_fail[p] = fl;
        port_prio[p*PW +: PW] = PW'(pr);
    endtask

    task automatic t_reset;
        step(2);
        check_sel(1, 15, "R1");
        rst_n = 1'b1;
        step(2);
        check_sel(1, 11, "R8");
    endtask

    task automatic t_rank;
        hold_ticks = 0;
        set_ext(4, 0, 0);
        set_port(0, 2, 0, 0); set_port(1, 6, 0, 0);
        set_port(2, 2, 0, 0); set_port(3, 9, 0, 0);
        step(2);
        check_sel(2, 2, "R5");          // quality and priority tie: port 0 first
        set_port(0, 2, 0, 3); set_port(2, 2, 0, 1);
        step(2);
        check_sel(4, 2, "R4");          // lower priority value wins
        set_ext(1, 0, 0);
        step(2);
        check_sel(0, 1, "R3");          // lowest quality code wins
        set_ext(2, 0, 1);
        step(2);
        check_sel(0, 2, "R5");          // ext ties port 2, lower index kept
    endtask

    task automatic t_dnu;
        set_ext(0, 1, 0);               // failed even with the best code
        set_port(0, 15, 0, 0);          // do-not-use from upstream
        set_port(1, 0, 1, 0);
        set_port(2, 1, 1, 0);
        set_port(3, 12, 0, 0);
        step(2);
        check_sel(5, 12, "R2");
        set_port(3, 12, 1, 0);
        step(2);
        check_sel(1, 11, "R8");
    endtask

    task automatic t_failover;
        hold_ticks = 0;
        set_port(0, 4, 1, 0); set_port(1, 3, 0, 0);
        set_port(2, 1, 1, 0); set_port(3, 5, 0, 0);
        step(2);
        check_sel(3, 3, "R6");          // zero hold-off: immediate adoption
        hold_ticks = 200;
        set_port(1, 3, 1, 0);           // current fails ...
        set_port(0, 4, 0, 0);           // ... while port 0 becomes best
        step(1);
        check_sel(2, 4, "R7");
    endtask

    task automatic t_hold;
        hold_ticks = 3;
        set_port(2, 3, 0, 0);
        step(3);
        check_sel(2, 4, "R6");
        pulse_ticks(2);
        check_sel(2, 4, "R6");
        set_port(3, 2, 0, 0);           // newer best restarts the count
        step(2);
        pulse_ticks(2);
        check_sel(2, 4, "R6");
        pulse_ticks(1);
        check_sel(5, 2, "R6");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rank();
        t_dnu();
        t_failover();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule